// File: doc/BRIEF.md
# Frame Stuffing Controller

This block decides, once per outgoing frame, how many stuff bits the frame carries. The aim is to keep the 6 ms transmit frame period aligned to the 6 ms PCM sync. An external measurement unit supplies an unsigned phase difference between the two frame references. A single-cycle frame strobe then asks for a decision against two programmed limits: a lower threshold B and an upper threshold C.

There are three outcomes. A small phase difference gives a frame with no stuffing. A moderate one gives a frame with four stuff bits, whose values come from a programmable 4-bit register. A phase difference above the upper limit is a stuffing error. On an error the block sets a sticky error flag and sends a one-cycle reset pulse to the transmit FIFO. Software clears the flag with a write-one-to-clear strobe. All results are registered and stay unchanged until the next frame strobe.

Top module: `stuff_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, stuffed_o, stuff_bits_o, stuff_err_o and fifo_rst_o are all 0 until the first frame strobe.
- R2: A strobe with phase_i <= thresh_b_i gives stuffed_o = 0 and stuff_bits_o = 4'b0000, with no error and no FIFO reset.
- R3: A strobe with thresh_b_i < phase_i <= thresh_c_i gives stuffed_o = 1, and stuff_bits_o equals stuff_val_i as sampled at the strobe, bit for bit (bit n of the register drives bit n of the output).
- R4: A strobe with phase_i > thresh_b_i and phase_i > thresh_c_i is a stuffing error: stuffed_o = 0, stuff_bits_o = 0, and stuff_err_o is set.
- R5: A stuffing error raises fifo_rst_o for exactly one cycle, in the cycle after the strobe edge. fifo_rst_o is never high at any other time.
- R6: stuff_err_o stays set across later non-error frames until err_clr_i is high at a clock edge. If err_clr_i and a new error decision fall on the same edge, the flag stays set.
- R7: Outside strobe cycles, changes on phase_i, thresh_b_i, thresh_c_i and stuff_val_i have no effect on stuffed_o or stuff_bits_o.
- R8: When thresh_c_i < thresh_b_i, a phase in the range (C, B] gives no stuffing and no error, because the threshold B test is applied first.
- R9: All outputs are registered. Results of a strobe at clock edge k appear right after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_stb_i | input | 1 | One-cycle frame decision strobe |
| phase_i | input | PHASE_W | Measured phase difference, unsigned |
| thresh_b_i | input | PHASE_W | Lower threshold B |
| thresh_c_i | input | PHASE_W | Upper threshold C |
| stuff_val_i | input | NSTUFF | Stuff bit values to send |
| err_clr_i | input | 1 | Write-one-to-clear for the error flag |
| stuffed_o | output | 1 | Decision status, 1 = stuff bits in this frame |
| stuff_bits_o | output | NSTUFF | Stuff bits for the frame, 0 when not stuffing |
| stuff_err_o | output | 1 | Sticky stuffing error flag |
| fifo_rst_o | output | 1 | One-cycle transmit FIFO reset pulse |

## Verification
Each decision result is due one clock after its strobe edge. The bench drives the strobe on a falling edge and samples on the next falling edge, which falls between the capturing rising edge and the following one. fifo_rst_o is checked high at that sample and low one falling edge later, which confirms the single-cycle width. The sticky flag and the hold behaviour are checked on the falling edge after each err_clr_i cycle, and after the inputs change with no strobe, before any further strobe is issued.

// File: rtl/stuff_pkg.sv
package stuff_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_STUFF = 2'd1,
    DEC_ERR   = 2'd2
  } stuff_dec_e;
endpackage

// File: rtl/stuff_decide.sv
module stuff_decide
  import stuff_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [PHASE_W-1:0] thresh_b_i,
  input  logic [PHASE_W-1:0] thresh_c_i,
  output stuff_dec_e         dec_o
);
  logic le_b, le_c;
  assign le_b = (phase_i <= thresh_b_i);
  assign le_c = (phase_i <= thresh_c_i);

  // B test first: a phase below B never stuffs or errors, even when C < B
  always_comb begin
    if (le_b)      dec_o = DEC_NONE;
    else if (le_c) dec_o = DEC_STUFF;
    else           dec_o = DEC_ERR;
  end

  always_comb begin
    if (le_b) assert (dec_o == DEC_NONE) else $error("p_below_b_none_r2");
  end
endmodule

// File: rtl/stuff_regs.sv
module stuff_regs
  import stuff_pkg::*;
#(
  parameter int NSTUFF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_stb_i,
  input  stuff_dec_e        dec_i,
  input  logic [NSTUFF-1:0] stuff_val_i,
  input  logic              err_clr_i,
  output logic              stuffed_o,
  output logic [NSTUFF-1:0] stuff_bits_o,
  output logic              stuff_err_o,
  output logic              fifo_rst_o
);
  logic              do_stuff, do_err;
  logic [NSTUFF-1:0] bits_d;

  assign do_stuff = frame_stb_i && (dec_i == DEC_STUFF);
  assign do_err   = frame_stb_i && (dec_i == DEC_ERR);

  for (genvar i = 0; i < NSTUFF; i++) begin : g_bits
    assign bits_d[i] = (dec_i == DEC_STUFF) & stuff_val_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stuffed_o    <= 1'b0;
      stuff_bits_o <= '0;
    end else if (frame_stb_i) begin
      stuffed_o    <= (dec_i == DEC_STUFF);
      stuff_bits_o <= bits_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stuff_err_o <= 1'b0;
      fifo_rst_o  <= 1'b0;
    end else begin
      fifo_rst_o <= do_err;
      if (do_err)         stuff_err_o <= 1'b1;  // set beats clear
      else if (err_clr_i) stuff_err_o <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_stb_i) |-> ($stable(stuffed_o) && $stable(stuff_bits_o)));

  p_fifo_after_stb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |-> $past(frame_stb_i));

  p_fifo_sets_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |-> stuff_err_o);

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_err_o && !err_clr_i) |=> stuff_err_o);

  p_no_stuff_on_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stuffed_o && fifo_rst_o));

  p_bits_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stuffed_o |-> (stuff_bits_o == '0));

  p_stuff_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_stuff |=> stuffed_o);
endmodule

// File: rtl/stuff_ctrl.sv
module stuff_ctrl
  import stuff_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int NSTUFF  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_stb_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [PHASE_W-1:0] thresh_b_i,
  input  logic [PHASE_W-1:0] thresh_c_i,
  input  logic [NSTUFF-1:0]  stuff_val_i,
  input  logic               err_clr_i,
  output logic               stuffed_o,
  output logic [NSTUFF-1:0]  stuff_bits_o,
  output logic               stuff_err_o,
  output logic               fifo_rst_o
);
  stuff_dec_e dec;

  stuff_decide #(.PHASE_W(PHASE_W)) u_decide (
    .phase_i    (phase_i),
    .thresh_b_i (thresh_b_i),
    .thresh_c_i (thresh_c_i),
    .dec_o      (dec)
  );

  stuff_regs #(.NSTUFF(NSTUFF)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_stb_i  (frame_stb_i),
    .dec_i        (dec),
    .stuff_val_i  (stuff_val_i),
    .err_clr_i    (err_clr_i),
    .stuffed_o    (stuffed_o),
    .stuff_bits_o (stuff_bits_o),
    .stuff_err_o  (stuff_err_o),
    .fifo_rst_o   (fifo_rst_o)
  );
endmodule

// File: tb/stuff_ctrl_bench.sv
module stuff_ctrl_bench;
  localparam int PW = 12;
  localparam int NS = 4;

  typedef struct packed {
    logic [PW-1:0] p;
    logic [PW-1:0] b;
    logic [PW-1:0] c;
    logic [NS-1:0] v;
    logic          es;
    logic [NS-1:0] eb;
    logic          ee;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{12'd50,   12'd100, 12'd200,  4'hA, 1'b0, 4'h0, 1'b0},  // R2
    '{12'd100,  12'd100, 12'd200,  4'hA, 1'b0, 4'h0, 1'b0},  // R2 edge
    '{12'd101,  12'd100, 12'd200,  4'hA, 1'b1, 4'hA, 1'b0},  // R3
    '{12'd200,  12'd100, 12'd200,  4'h5, 1'b1, 4'h5, 1'b0},  // R3 edge
    '{12'd201,  12'd100, 12'd200,  4'hF, 1'b0, 4'h0, 1'b1},  // R4
    '{12'd0,    12'd0,   12'd10,   4'hF, 1'b0, 4'h0, 1'b0},  // R2
    '{12'd4095, 12'd0,   12'd4095, 4'h9, 1'b1, 4'h9, 1'b0},  // R3 max
    '{12'd80,   12'd100, 12'd50,   4'hF, 1'b0, 4'h0, 1'b0},  // R8
    '{12'd150,  12'd100, 12'd50,   4'hF, 1'b0, 4'h0, 1'b1},  // R8 err
    '{12'd1,    12'd0,   12'd0,    4'h3, 1'b0, 4'h0, 1'b1}   // R4
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_stb_i = 1'b0;
  logic [PW-1:0] phase_i = '0, thresh_b_i = '0, thresh_c_i = '0;
  logic [NS-1:0] stuff_val_i = '0;
  logic          err_clr_i = 1'b0;
  logic          stuffed_o, stuff_err_o, fifo_rst_o;
  logic [NS-1:0] stuff_bits_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stuff_ctrl #(.PHASE_W(PW), .NSTUFF(NS)) u_stuff_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .frame_stb_i(frame_stb_i),
    .phase_i(phase_i), .thresh_b_i(thresh_b_i), .thresh_c_i(thresh_c_i),
    .stuff_val_i(stuff_val_i), .err_clr_i(err_clr_i),
    .stuffed_o(stuffed_o), .stuff_bits_o(stuff_bits_o),
    .stuff_err_o(stuff_err_o), .fifo_rst_o(fifo_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_in(input vec_t t);
    phase_i = t.p; thresh_b_i = t.b; thresh_c_i = t.c; stuff_val_i = t.v;
  endtask

  // strobe on a falling edge; returns on the falling edge after capture
  task automatic frame(input bit clr);
    frame_stb_i = 1'b1; err_clr_i = clr;
    @(negedge clk);
    frame_stb_i = 1'b0; err_clr_i = 1'b0;
  endtask

  task automatic clear_err();
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk("R1 stuffed in reset", 32'(stuffed_o), 0);
    chk("R1 fifo in reset", 32'(fifo_rst_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 bits after reset", 32'(stuff_bits_o), 0);
    chk("R1 err after reset", 32'(stuff_err_o), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_in(VEC[i]);
      frame(1'b0);
      // R9: result due right after the capturing edge
      chk($sformatf("R2/R3 stuffed vec%0d", i), 32'(stuffed_o), 32'(VEC[i].es));
      chk($sformatf("R3 bits vec%0d", i), 32'(stuff_bits_o), 32'(VEC[i].eb));
      chk($sformatf("R4 err vec%0d", i), 32'(stuff_err_o), 32'(VEC[i].ee));
      chk($sformatf("R5 fifo pulse vec%0d", i), 32'(fifo_rst_o), 32'(VEC[i].ee));
      @(negedge clk);
      chk($sformatf("R5 fifo width vec%0d", i), 32'(fifo_rst_o), 0);
      if (VEC[i].ee) begin
        clear_err();
        chk($sformatf("R6 clear vec%0d", i), 32'(stuff_err_o), 0);
      end
    end

    // R7: input changes with no strobe are ignored
    set_in(VEC[2]); frame(1'b0);
    chk("R7 setup stuffed", 32'(stuffed_o), 1);
    set_in(VEC[0]); stuff_val_i = 4'h6;
    repeat (3) @(negedge clk);
    chk("R7 stuffed held", 32'(stuffed_o), 1);
    chk("R7 bits held", 32'(stuff_bits_o), 32'hA);
    set_in(VEC[4]);
    repeat (2) @(negedge clk);
    chk("R7 no err without strobe", 32'(stuff_err_o), 0);
    chk("R7 no fifo without strobe", 32'(fifo_rst_o), 0);

    // R6: sticky across non-error frames
    set_in(VEC[4]); frame(1'b0);
    chk("R6 err set", 32'(stuff_err_o), 1);
    set_in(VEC[2]); frame(1'b0);
    chk("R6 err sticky", 32'(stuff_err_o), 1);
    chk("R6 fifo quiet on stuff", 32'(fifo_rst_o), 0);
    set_in(VEC[0]); frame(1'b0);
    @(negedge clk);
    chk("R6 err still sticky", 32'(stuff_err_o), 1);
    // R6: set wins over clear on same edge
    set_in(VEC[4]); frame(1'b1);
    chk("R6 set beats clear", 32'(stuff_err_o), 1);
    chk("R5 pulse on second error", 32'(fifo_rst_o), 1);
    clear_err();
    chk("R6 cleared", 32'(stuff_err_o), 0);

    // R1: asynchronous reset mid-run
    set_in(VEC[3]); frame(1'b0);
    #1 rst_ni = 1'b0;
    #1 chk("R1 async reset stuffed", 32'(stuffed_o), 0);
    chk("R1 async reset bits", 32'(stuff_bits_o), 0);
    rst_ni = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule